// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame should be kept. It looks only at the destination address. The address arrives as six bytes, one per accepted clock, with a start strobe on the first byte. The block weighs four separately enabled paths and ORs them into one accept flag:

- an exact match against a programmed station address;
- broadcast acceptance;
- hash-filtered multicast acceptance;
- promiscuous acceptance.

The multicast path uses a 6-bit hash index produced by an external CRC unit, which selects one bit of a 64-bit filter table.

One cycle after the sixth address byte, the block raises a one-cycle done strobe and presents its decision on the accept flag. The accept flag keeps that value until the next decision. The receive path upstream uses the flag to keep or drop the rest of the frame. Frames may follow one another back to back, and each start strobe begins a fresh judgement.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `accept` are 0.
- R2: Byte k of the address (k = 0 arrives first, with `frm_start`) is compared with `stn_addr[8k+7:8k]`. When all six bytes are equal, the frame is accepted whatever the configuration bits are.
- R3: A difference in any single byte position defeats the exact-match path. With all configuration bits clear, such a frame is rejected.
- R4: A frame whose six bytes are all FFh is a broadcast. Without an exact match, it is accepted exactly when `cfg_bcast_en` is 1.
- R5: When `cfg_promisc` is 1, every non-broadcast frame is accepted. The promiscuous path never accepts a broadcast.
- R6: A frame is multicast when bit 0 of byte 0 is 1 and the frame is not a broadcast. Such a frame is accepted by the hash path when `cfg_mcast_en` is 1 and `mcast_tbl[hash_idx]` is 1; index value n selects table bit n. A broadcast frame never passes the hash path.
- R7: `hash_idx` is sampled only in the cycle that carries the sixth address byte. Its value in earlier cycles has no effect.
- R8: `done` is high for exactly one cycle, the cycle after the sixth accepted byte. `accept` changes only together with `done` and holds its value otherwise.
- R9: `frm_start` together with `byte_vld` always starts a new address at byte 0. A partially received address is discarded and produces no `done`.
- R10: Cycles with `byte_vld` low pause the byte sequence without losing progress. Bytes arriving after the sixth byte, without a new start, are ignored and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Marks byte 0 of a new destination address (qualified by byte_vld) |
| byte_vld | input | 1 | byte_in carries an address byte this cycle |
| byte_in | input | 8 | Destination address byte |
| stn_addr | input | 48 | Station address; byte k in bits [8k+7:8k] |
| mcast_tbl | input | 64 | Multicast hash filter table |
| hash_idx | input | 6 | Hash of the destination address, valid with the sixth byte |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Accept multicast frames whose hash bit is set |
| cfg_promisc | input | 1 | Accept every non-broadcast frame |
| accept | output | 1 | Decision for the last judged frame |
| done | output | 1 | One-cycle strobe: a new decision is on accept |

## Verification
The exact-match path is tried with one address that matches the station fully. It is also tried with six variants, each differing in exactly one byte position, which separates a correct AND over all bytes from one that drops or repeats a byte index.

Broadcast, multicast and plain unicast addresses are each tried under different settings of the enable bits and hash table. This distinguishes the three gated paths from one another, and shows that broadcast is excluded from both the promiscuous and hash paths.

The hash index is driven with a misleading value before the sixth byte. Byte streams with idle gaps, aborted partial addresses and trailing stray bytes check that the byte position is tracked correctly and that `done` arrives exactly once per complete address.

// File: rtl/dafilt_pkg.sv
// Package: shared sizes for the destination address filter.
// Assumes a standard 6-byte Ethernet address and a 6-bit hash.
package dafilt_pkg;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned HASH_W     = 6;
endpackage

// File: rtl/dafilt_seq.sv
// Byte sequencer: tracks which address byte is on the input.
// frm_start with byte_vld forces position 0. After the last byte the
// sequencer goes idle and ignores bytes until the next start.
module dafilt_seq #(
    parameter int unsigned NB = dafilt_pkg::ADDR_BYTES,
    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          byte_vld,
    output logic          take,
    output logic          first,
    output logic          last,
    output logic [IW-1:0] idx
);
    logic          active;
    logic [IW-1:0] pos;

    // Current byte position and qualifiers for this cycle.
    always_comb begin
        idx   = frm_start ? '0 : pos;
        take  = byte_vld && (frm_start || active);
        first = take && frm_start;
        last  = take && (idx == IW'(NB - 1));
    end

    // Advance the position on each taken byte; go idle after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (take) begin
            if (last) begin
                active <= 1'b0;
                pos    <= '0;
            end else begin
                active <= 1'b1;
                pos    <= idx + IW'(1);
            end
        end
    end
endmodule

// File: rtl/dafilt_match.sv
// Address classifier: accumulates exact-match, all-ones and group-bit
// flags across the address bytes. The *_now outputs already include the
// byte on the input this cycle. Assumes idx only selects valid bytes when
// take is high.
module dafilt_match #(
    parameter int unsigned NB = dafilt_pkg::ADDR_BYTES,
    parameter int unsigned BW = dafilt_pkg::BYTE_W,
    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
    localparam int unsigned NS = 1 << IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [BW-1:0]  byte_in,
    input  logic [NB*BW-1:0] stn_addr,
    input  logic           take,
    input  logic           first,
    input  logic [IW-1:0]  idx,
    output logic           uc_now,
    output logic           bc_now,
    output logic           mc_now
);
    logic [NS-1:0] eq_vec;
    logic          eq_sel;
    logic          uc_acc, bc_acc, mc_r;

    // One comparator per station byte; unused slots never match.
    for (genvar k = 0; k < NS; k++) begin : g_cmp
        if (k < NB) begin : g_real
            assign eq_vec[k] = (stn_addr[k*BW +: BW] == byte_in);
        end else begin : g_pad
            assign eq_vec[k] = 1'b0;
        end
    end

    // Merge this cycle's byte with the flags gathered so far.
    always_comb begin
        eq_sel = eq_vec[idx];
        uc_now = (first ? 1'b1 : uc_acc) && eq_sel;
        bc_now = (first ? 1'b1 : bc_acc) && (byte_in == {BW{1'b1}});
        mc_now = first ? byte_in[0] : mc_r;
    end

    // Keep the flags for the next byte; a start restarts them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uc_acc <= 1'b0;
            bc_acc <= 1'b0;
            mc_r   <= 1'b0;
        end else if (take) begin
            uc_acc <= uc_now;
            bc_acc <= bc_now;
            mc_r   <= mc_now;
        end
    end
endmodule

// File: rtl/dafilt_hash.sv
// Hash lookup: returns the filter-table bit selected by the hash index.
// The table is flat: index n selects bit n.
module dafilt_hash #(
    parameter int unsigned HW = dafilt_pkg::HASH_W,
    localparam int unsigned TB = 1 << HW
) (
    input  logic [TB-1:0] tbl,
    input  logic [HW-1:0] hidx,
    output logic          hit
);
    // Single-bit select from the table.
    always_comb hit = tbl[hidx];
endmodule

// File: rtl/rx_dest_filter.sv
// Destination address filter top. Combines the exact-match, broadcast,
// hash-multicast and promiscuous paths, and registers the decision one
// cycle after the last address byte. Assumes hash_idx is valid with the
// last byte.
module rx_dest_filter #(
    parameter int unsigned NB = dafilt_pkg::ADDR_BYTES,
    parameter int unsigned BW = dafilt_pkg::BYTE_W,
    parameter int unsigned HW = dafilt_pkg::HASH_W,
    localparam int unsigned AW = NB * BW,
    localparam int unsigned TB = 1 << HW,
    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          byte_vld,
    input  logic [BW-1:0] byte_in,
    input  logic [AW-1:0] stn_addr,
    input  logic [TB-1:0] mcast_tbl,
    input  logic [HW-1:0] hash_idx,
    input  logic          cfg_bcast_en,
    input  logic          cfg_mcast_en,
    input  logic          cfg_promisc,
    output logic          accept,
    output logic          done
);
    logic          take, first, last;
    logic [IW-1:0] idx;
    logic          uc_now, bc_now, mc_now, hit;
    logic          verdict;

    dafilt_seq #(.NB(NB)) u_seq (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
        .take(take), .first(first), .last(last), .idx(idx)
    );

    dafilt_match #(.NB(NB), .BW(BW)) u_match (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .stn_addr(stn_addr),
        .take(take), .first(first), .idx(idx),
        .uc_now(uc_now), .bc_now(bc_now), .mc_now(mc_now)
    );

    dafilt_hash #(.HW(HW)) u_hash (
        .tbl(mcast_tbl), .hidx(hash_idx), .hit(hit)
    );

    // OR of the four gated acceptance paths.
    always_comb begin
        verdict = uc_now
                | (bc_now && cfg_bcast_en)
                | (mc_now && !bc_now && cfg_mcast_en && hit)
                | (!bc_now && cfg_promisc);
    end

    // Register the strobe and capture the decision on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done <= last;
            if (last) accept <= verdict;
        end
    end
endmodule

// File: rtl/dafilt_chk.sv
// Checker for rx_dest_filter: timing of done, holding of accept,
// the promiscuous path and the reset state, all seen at the ports.
module dafilt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic [7:0] byte_in,
    input logic       cfg_promisc,
    input logic       accept,
    input logic       done
);
    // R1: reset clears both outputs.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !accept));

    // R8: a done strobe always follows a cycle with a valid byte.
    assert_done_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_vld));

    // R8: done lasts exactly one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: accept moves only together with done.
    assert_accept_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(accept));

    // R5: promiscuous mode with a non-FF last byte must accept.
    assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(cfg_promisc) && $past(byte_in != 8'hFF)) |-> accept);
endmodule

bind rx_dest_filter dafilt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .cfg_promisc(cfg_promisc), .accept(accept), .done(done)
);

// File: tb/tb_rx_dest_filter.sv
// Scoreboard bench: the driver pushes the expected decision for each
// complete address; a monitor pops and compares on every done strobe.
module tb_rx_dest_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [47:0] stn_addr = '0;
    logic [63:0] mcast_tbl = '0;
    logic [5:0]  hash_idx = '0;
    logic        cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0, cfg_promisc = 1'b0;
    logic        accept, done;

    int errs = 0, checks = 0, hold_err = 0, done_seen = 0, pushed = 0;
    logic exp_q[$];
    string tag_q[$];
    logic last_acc = 1'b0;

    localparam logic [47:0] STN = 48'h5A_4B_3C_2D_1E_02;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

    always #2.5 clk = ~clk;

    rx_dest_filter dut (.*);

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    function automatic logic model(input logic [47:0] da, input logic [5:0] h);
        logic bc, mc, uc;
        bc = (da == BC);
        mc = da[0] && !bc;
        uc = (da == stn_addr);
        return uc | (bc && cfg_bcast_en) | (mc && cfg_mcast_en && mcast_tbl[h])
             | (!bc && cfg_promisc);
    endfunction

    // Drive n bytes of an address; a full six pushes an expected result.
    task automatic drive(input logic [47:0] da, input logic [5:0] h,
                         input int n, input bit gaps, input string tag);
        if (n == 6) begin
            exp_q.push_back(model(da, h));
            tag_q.push_back(tag);
            pushed++;
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frm_start = (k == 0);
            byte_vld  = 1'b1;
            byte_in   = da[8*k +: 8];
            hash_idx  = (k == 5) ? h : ~h;
            if (gaps) begin
                @(negedge clk);
                frm_start = 1'b0;
                byte_vld  = 1'b0;
                byte_in   = 8'hFF;
            end
        end
        @(negedge clk);
        frm_start = 1'b0;
        byte_vld  = 1'b0;
        hash_idx  = ~h;
    endtask

    task automatic send(input logic [47:0] da, input logic [5:0] h, input string tag);
        drive(da, h, 6, 1'b0, tag);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare on done, watch accept holding otherwise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    checks++; errs++;
                    $display("FAIL R10: actual=done expected=no done");
                end else begin
                    check(accept, exp_q.pop_front(), tag_q.pop_front());
                end
                last_acc = accept;
            end else if (accept !== last_acc) begin
                hold_err++;
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        stn_addr = STN;
        repeat (3) @(negedge clk);
        check(done, 1'b0, "R1 done in reset");
        check(accept, 1'b0, "R1 accept in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(done, 1'b0, "R1 done after reset");

        send(STN, 6'd0, "R2 exact match, config clear");
        cfg_bcast_en = 1; cfg_mcast_en = 1;
        send(STN, 6'd0, "R2 exact match, config set");
        cfg_bcast_en = 0; cfg_mcast_en = 0;
        for (int k = 0; k < 6; k++)
            send(STN ^ (48'h04 << (8 * k)), 6'd0, $sformatf("R3 mismatch in byte %0d", k));

        send(BC, 6'd0, "R4 broadcast disabled");
        cfg_bcast_en = 1;
        send(BC, 6'd0, "R4 broadcast enabled");
        cfg_bcast_en = 0;

        cfg_promisc = 1;
        send(48'h11_22_33_44_55_66, 6'd0, "R5 promiscuous unicast");
        send(48'h11_22_33_44_55_67, 6'd0, "R5 promiscuous multicast");
        send(BC, 6'd0, "R5 promiscuous excludes broadcast");
        cfg_promisc = 0;

        mcast_tbl = 64'h1 << 32;
        cfg_mcast_en = 1;
        send(48'hA0_B0_C0_D0_E0_01, 6'd32, "R6 hash hit bit 32");
        send(48'hA0_B0_C0_D0_E0_01, 6'd33, "R6 hash miss bit 33");
        send(48'hA0_B0_C0_D0_E0_00, 6'd32, "R6 unicast ignores hash");
        mcast_tbl = 64'h1 << 31;
        send(48'hA0_B0_C0_D0_E0_01, 6'd32, "R7 early index ignored");
        mcast_tbl = '1;
        send(BC, 6'd5, "R6 broadcast excluded from hash");
        cfg_mcast_en = 0;
        send(48'hA0_B0_C0_D0_E0_01, 6'd32, "R6 multicast disabled");

        drive(48'h11_22_33_44_55_66, 6'd0, 3, 1'b0, "R9 partial");
        drive(STN, 6'd0, 6, 1'b0, "R9 restart after partial");
        repeat (2) @(negedge clk);
        drive(STN, 6'd0, 4, 1'b0, "R9 partial");
        frm_start = 1'b0;
        drive(STN ^ 48'h0100, 6'd0, 6, 1'b0, "R9 restart judged on new bytes");
        repeat (2) @(negedge clk);

        drive(STN, 6'd0, 6, 1'b1, "R10 gapped bytes");
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_in  = STN[8*k +: 8];
        end
        @(negedge clk);
        byte_vld = 1'b0;
        repeat (4) @(negedge clk);

        check(exp_q.size() == 0, 1'b1, "R8 every expected decision seen");
        check(done_seen == pushed, 1'b1, "R8 done count equals full addresses");
        check(hold_err == 0, 1'b1, "R8 accept held between strobes");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule